// File: doc/BRIEF.md
# Interrupt Controller Command and Initialization Sequencer

This block is the register-facing half of an eight-line priority interrupt controller. Software talks to it through a one-bit address and an eight-bit data port. Writes to address 0 are either an initialization start word or a command word. Writes to address 1 either continue the initialization sequence or load the mask register. The block holds the mask, the vector base, the in-service register, the rotating priority offset and the mode flags (auto end-of-interrupt, rotate-on-auto-end-of-interrupt, nested mode, special mask, poll and read-select).

The request register comes from an external capture stage on `req_vec`. The block tells that stage which request bits to drop on `req_clr` and pulses `cap_init` when initialization restarts. A priority picker finds the winning unmasked request under the current rotation. `int_req` rises when that request outranks everything in service. An `ack` pulse latches the vector in `ack_vec` and moves the line into service. End-of-interrupt commands clear in-service bits and can move the priority offset.

The initialization machine has four states. ST_RUN is the normal state. ST_BASE waits for the base word, ST_CASC waits for the cascade word, and ST_MODE waits for the mode word. The transitions are:
- any state to ST_BASE on a start word;
- ST_BASE to ST_CASC on an address-1 write;
- ST_CASC to ST_MODE when the start word asked for a mode word, or to ST_RUN when it did not;
- ST_MODE to ST_RUN on an address-1 write.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset the sequencer is in ST_RUN. Mask, base, in-service register, offset, every flag, `rd_data`, `ack_vec` and `int_req` are all zero.
- R2: An address-0 write with data bit 4 set is a start word. In that cycle it pulses `cap_init` and drives `req_clr` = ~`level_sel`. It clears the mask, the offset, the special mask and read-select, and it latches data bit 0 as "mode word needed". If bit 0 is 0 it also clears nested mode and auto end-of-interrupt. The next state is ST_BASE.
- R3: In ST_BASE an address-1 write loads base = data & 0xF8 and moves to ST_CASC. The next address-1 write moves to ST_MODE if a mode word is needed, else to ST_RUN. In ST_MODE an address-1 write loads nested mode from bit 4 and auto end-of-interrupt from bit 1, then returns to ST_RUN. None of these writes touches the mask.
- R4: In ST_RUN an address-1 write loads the mask, and an address-1 read returns it.
- R5: An address-0 write with bit 4 = 0 and bit 3 = 1 sets poll if bit 2 is 1. It loads read-select from bit 0 only if bit 1 is 1, and loads special mask from bit 5 only if bit 6 is 1.
- R6: Command code 1 (address 0, bits 4:3 = 00, bits 7:5 = 001) clears the in-service bit that has the highest priority under the current rotation. Code 5 does the same and also sets the offset to that line + 1. An empty in-service register is left unchanged.
- R7: Code 3 clears in-service bit data[2:0]. Code 7 clears it and sets the offset to data[2:0] + 1.
- R8: Code 6 sets the offset to data[2:0] + 1, modulo 8. Codes 0 and 4 load rotate-on-auto-end-of-interrupt from bit 7. Code 2 has no effect.
- R9: Priority runs from line `offset` (highest) upward, wrapping modulo 8. `int_req` is 1 exactly when some line of `req_vec & ~mask` exists and its priority is strictly higher than that of every in-service line.
- R10: On `ack` with a winner, the winner's in-service bit is set. `ack_vec` becomes base | line one cycle later, and during the `ack` cycle `req_clr` has the winner's bit set if `level_sel` marks that line edge-triggered (0). On `ack` with no winner, `ack_vec` becomes base | 7 and nothing else changes.
- R11: With auto end-of-interrupt set, an `ack` leaves the in-service register unchanged. If rotate-on-auto-end-of-interrupt is also set, the offset becomes line + 1.
- R12: A read while poll is set returns the winning line number in `rd_data` one cycle later. In the read cycle it drives the winner's bit on `req_clr` and clears the winner's in-service bit. With no winner it returns 7 and clears nothing. Poll is cleared after the read.
- R13: A non-poll address-0 read returns the in-service register if read-select is 1, else `req_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| req_vec | input | 8 | Request register from the capture stage |
| level_sel | input | 8 | Per-line trigger type, 1 = level |
| ack | input | 1 | Interrupt acknowledge pulse |
| int_req | output | 1 | Interrupt request to the processor |
| ack_vec | output | 8 | Vector latched on acknowledge |
| req_clr | output | 8 | Request bits for the capture stage to drop this cycle |
| cap_init | output | 1 | Start-word pulse to the capture stage |
| nest_mode | output | 1 | Nested-mode flag |
| spec_mask | output | 1 | Special-mask flag |

## Verification
The hardest state to reach is a rotated offset combined with several in-service lines. There, the non-specific end-of-interrupt must pick a line other than the lowest-numbered one. Only acknowledge cycles can build the in-service register, so the bench first acknowledges line 0 under the default order. It then sets the offset with code 6 so that line 6 outranks line 0, and acknowledges again. The following non-specific end-of-interrupt must clear line 6 and leave line 0 in service. Rotation after acknowledge is proven in the same way, through the vectors of back-to-back acknowledges with two pending lines.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    localparam logic [2:0] CMD_ROT_OFF = 3'd0;
    localparam logic [2:0] CMD_EOI     = 3'd1;
    localparam logic [2:0] CMD_NOP     = 3'd2;
    localparam logic [2:0] CMD_SEOI    = 3'd3;
    localparam logic [2:0] CMD_ROT_ON  = 3'd4;
    localparam logic [2:0] CMD_REOI    = 3'd5;
    localparam logic [2:0] CMD_SETPRI  = 3'd6;
    localparam logic [2:0] CMD_RSEOI   = 3'd7;

endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int NLINES = 8,
    parameter int LW     = $clog2(NLINES)
) (
    input  logic [NLINES-1:0] vec,
    input  logic [LW-1:0]     off,
    output logic              any,
    output logic [LW-1:0]     prio,
    output logic [LW-1:0]     line
);
    logic [LW-1:0] idx;

    // lowest rotated priority number wins; line = (prio + off) mod NLINES
    always_comb begin
        any  = 1'b0;
        prio = '0;
        line = '0;
        idx  = '0;
        for (int p = NLINES - 1; p >= 0; p--) begin
            idx = LW'(p) + off;
            if (vec[idx]) begin
                any  = 1'b1;
                prio = LW'(p);
                line = idx;
            end
        end
    end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  logic     start_need,
    input  logic     data_wr,
    output init_st_e st,
    output logic     base_ld,
    output logic     mode_ld,
    output logic     mask_ld
);
    init_st_e st_q, st_d;
    logic     need_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            need_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start) need_q <= start_need;
        end
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d = ST_BASE;
        end else if (data_wr) begin
            unique case (st_q)
                ST_RUN:  st_d = ST_RUN;
                ST_BASE: st_d = ST_CASC;
                ST_CASC: st_d = need_q ? ST_MODE : ST_RUN;
                ST_MODE: st_d = ST_RUN;
            endcase
        end
    end

    always_comb begin
        base_ld = 1'b0;
        mode_ld = 1'b0;
        mask_ld = 1'b0;
        if (data_wr && !start) begin
            unique case (st_q)
                ST_RUN:  mask_ld = 1'b1;
                ST_BASE: base_ld = 1'b1;
                ST_CASC: ;
                ST_MODE: mode_ld = 1'b1;
            endcase
        end
    end

    assign st = st_q;
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NLINES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] req_vec,
    input  logic [DW-1:0] level_sel,
    input  logic          ack,
    output logic          int_req,
    output logic [DW-1:0] ack_vec,
    output logic [DW-1:0] req_clr,
    output logic          cap_init,
    output logic          nest_mode,
    output logic          spec_mask
);
    localparam int            LW        = $clog2(NLINES);
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(NLINES - 1);
    localparam logic [LW-1:0] SPUR_LINE = LW'(NLINES - 1);

    logic [DW-1:0] mask_q, base_q, isr_q, rd_q, vec_q;
    logic [LW-1:0] off_q, off_nx;
    logic          aeoi_q, rot_q, nest_q, smask_q, poll_q, rsel_q;

    function automatic logic [DW-1:0] oh(input logic [LW-1:0] l);
        oh = DW'(1) << l;
    endfunction

    // command decode
    logic       icw1, ocw3, ocw2, data_wr;
    logic [2:0] cmd;
    assign icw1    = wr_en && !addr && wr_data[4];
    assign ocw3    = wr_en && !addr && !wr_data[4] && wr_data[3];
    assign ocw2    = wr_en && !addr && !wr_data[4] && !wr_data[3];
    assign data_wr = wr_en && addr;
    assign cmd     = wr_data[7:5];

    init_st_e init_st;
    logic     base_ld, mode_ld, mask_ld;

    pic_init_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (icw1),
        .start_need(wr_data[0]),
        .data_wr   (data_wr),
        .st        (init_st),
        .base_ld   (base_ld),
        .mode_ld   (mode_ld),
        .mask_ld   (mask_ld)
    );

    logic          req_any, isr_any;
    logic [LW-1:0] req_prio, req_line, isr_prio, isr_line;

    pic_prio_pick #(.NLINES(NLINES), .LW(LW)) u_req_pick (
        .vec (req_vec & ~mask_q),
        .off (off_q),
        .any (req_any),
        .prio(req_prio),
        .line(req_line)
    );

    pic_prio_pick #(.NLINES(NLINES), .LW(LW)) u_isr_pick (
        .vec (isr_q),
        .off (off_q),
        .any (isr_any),
        .prio(isr_prio),
        .line(isr_line)
    );

    logic win;
    assign win = req_any && (!isr_any || (req_prio < isr_prio));

    logic [DW-1:0] isr_set, isr_clr, clr_c;
    logic          off_ld, rot_ld;

    always_comb begin
        isr_set = '0;
        isr_clr = '0;
        clr_c   = '0;
        off_ld  = 1'b0;
        off_nx  = off_q;
        rot_ld  = 1'b0;
        if (icw1) clr_c = ~level_sel;
        if (ocw2) begin
            case (cmd)
                CMD_ROT_OFF, CMD_ROT_ON: rot_ld = 1'b1;
                CMD_EOI, CMD_REOI: begin
                    if (isr_any) begin
                        isr_clr = oh(isr_line);
                        if (cmd == CMD_REOI) begin
                            off_ld = 1'b1;
                            off_nx = isr_line + LW'(1);
                        end
                    end
                end
                CMD_SEOI: isr_clr = oh(wr_data[LW-1:0]);
                CMD_SETPRI: begin
                    off_ld = 1'b1;
                    off_nx = wr_data[LW-1:0] + LW'(1);
                end
                CMD_RSEOI: begin
                    isr_clr = oh(wr_data[LW-1:0]);
                    off_ld  = 1'b1;
                    off_nx  = wr_data[LW-1:0] + LW'(1);
                end
                default: ;
            endcase
        end
        if (ack && win) begin
            if (!level_sel[req_line]) clr_c = clr_c | oh(req_line);
            if (aeoi_q) begin
                if (rot_q) begin
                    off_ld = 1'b1;
                    off_nx = req_line + LW'(1);
                end
            end else begin
                isr_set = oh(req_line);
            end
        end
        if (rd_en && poll_q && win) begin
            clr_c   = clr_c | oh(req_line);
            isr_clr = isr_clr | oh(req_line);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            base_q  <= '0;
            isr_q   <= '0;
            off_q   <= '0;
            aeoi_q  <= 1'b0;
            rot_q   <= 1'b0;
            nest_q  <= 1'b0;
            smask_q <= 1'b0;
            poll_q  <= 1'b0;
            rsel_q  <= 1'b0;
            rd_q    <= '0;
            vec_q   <= '0;
        end else begin
            if (icw1) begin
                mask_q  <= '0;
                off_q   <= '0;
                smask_q <= 1'b0;
                rsel_q  <= 1'b0;
                if (!wr_data[0]) begin
                    nest_q <= 1'b0;
                    aeoi_q <= 1'b0;
                end
            end else if (off_ld) begin
                off_q <= off_nx;
            end
            if (mask_ld) mask_q <= wr_data;
            if (base_ld) base_q <= wr_data & BASE_KEEP;
            if (mode_ld) begin
                nest_q <= wr_data[4];
                aeoi_q <= wr_data[1];
            end
            if (ocw3) begin
                if (wr_data[2]) poll_q  <= 1'b1;
                if (wr_data[1]) rsel_q  <= wr_data[0];
                if (wr_data[6]) smask_q <= wr_data[5];
            end
            if (rot_ld) rot_q <= wr_data[7];
            isr_q <= (isr_q & ~isr_clr) | isr_set;
            if (ack) vec_q <= base_q | DW'(win ? req_line : SPUR_LINE);
            if (rd_en) begin
                if (poll_q) begin
                    poll_q <= 1'b0;
                    rd_q   <= DW'(win ? req_line : SPUR_LINE);
                end else begin
                    rd_q <= addr ? mask_q : (rsel_q ? isr_q : req_vec);
                end
            end
        end
    end

    assign rd_data   = rd_q;
    assign ack_vec   = vec_q;
    assign int_req   = win;
    assign req_clr   = clr_c;
    assign cap_init  = icw1;
    assign nest_mode = nest_q;
    assign spec_mask = smask_q;
endmodule

// File: rtl/pic_seq_chk.sv
module pic_seq_chk
    import pic_seq_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NLINES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          addr,
    input logic [DW-1:0] wr_data,
    input logic          ack,
    input logic          int_req,
    input logic [DW-1:0] req_vec,
    input logic [DW-1:0] mask_q,
    input logic [DW-1:0] base_q,
    input logic [DW-1:0] isr_q,
    input logic          poll_q,
    input logic          aeoi_q,
    input init_st_e      st
);
    localparam int LW = $clog2(NLINES);

    assert_start_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[4]) |=> (mask_q == '0 && st == ST_BASE));

    assert_base_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && st == ST_BASE) |=>
        (base_q[LW-1:0] == '0 && base_q[DW-1:LW] == $past(wr_data[DW-1:LW])));

    assert_eoi_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wr_data[7:3] == 5'b00100 && isr_q != '0 && !ack && !rd_en)
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    assert_req_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((req_vec & ~mask_q) != '0));

    assert_auto_eoi_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi_q && !wr_en && !rd_en) |=> (isr_q == $past(isr_q)));

    assert_poll_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_q && !wr_en) |=> !poll_q);
endmodule

bind pic_cmd_seq pic_seq_chk #(.DW(DW), .NLINES(NLINES)) u_pic_seq_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wr_data(wr_data),
    .ack    (ack),
    .int_req(int_req),
    .req_vec(req_vec),
    .mask_q (mask_q),
    .base_q (base_q),
    .isr_q  (isr_q),
    .poll_q (poll_q),
    .aeoi_q (aeoi_q),
    .st     (init_st)
);

// File: tb/test_pic_cmd_seq.sv
module test_pic_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0, req_vec = '0, level_sel = '0;
    logic [7:0] rd_data, ack_vec, req_clr;
    logic       int_req, cap_init, nest_mode, spec_mask;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pic_cmd_seq i_pic_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .req_vec(req_vec),
        .level_sel(level_sel), .ack(ack), .int_req(int_req), .ack_vec(ack_vec),
        .req_clr(req_clr), .cap_init(cap_init), .nest_mode(nest_mode),
        .spec_mask(spec_mask)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic do_ack(output logic [7:0] clr, output logic [7:0] v);
        ack = 1'b1;
        #1 clr = req_clr;
        @(negedge clk);
        ack = 1'b0;
        v = ack_vec;
    endtask

    task automatic set_req(input logic [7:0] r);
        req_vec = r;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 int_req", {7'd0, int_req}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 ack_vec", ack_vec, 8'h00);
        chk("R1 flags", {6'd0, nest_mode, spec_mask}, 8'd0);
        rd(1'b1, v); chk("R1 mask", v, 8'h00);
        set_req(8'h5A);
        rd(1'b0, v); chk("R1 read-select clear", v, 8'h5A);
        set_req(8'h00);
    endtask

    task automatic t_init();
        logic [7:0] v;
        level_sel = 8'h0F;
        wr(1'b1, 8'hAA);
        rd(1'b1, v); chk("R4 mask load", v, 8'hAA);
        wr_en = 1'b1; addr = 1'b0; wr_data = 8'h11;
        #1;
        chk("R2 cap_init", {7'd0, cap_init}, 8'd1);
        chk("R2 req_clr", req_clr, 8'hF0);
        @(negedge clk); wr_en = 1'b0;
        rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
        wr(1'b1, 8'h47);
        rd(1'b1, v); chk("R3 base word leaves mask", v, 8'h00);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h12);
        chk("R3 mode word nest", {7'd0, nest_mode}, 8'd1);
        wr(1'b1, 8'h33);
        rd(1'b1, v); chk("R4 back in run", v, 8'h33);
        wr(1'b0, 8'h10);
        chk("R2 nest cleared", {7'd0, nest_mode}, 8'd0);
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h5C);
        rd(1'b1, v); chk("R3 no mode word", v, 8'h5C);
        wr(1'b1, 8'h00);
        level_sel = 8'h00;
    endtask

    task automatic t_ack();
        logic [7:0] c, v;
        set_req(8'h28);
        chk("R9 int_req on", {7'd0, int_req}, 8'd1);
        do_ack(c, v);
        chk("R10 req_clr edge", c, 8'h08);
        chk("R10 ack_vec", v, 8'h83);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R10 isr set", v, 8'h08);
        set_req(8'h20);
        chk("R9 blocked by isr", {7'd0, int_req}, 8'd0);
        set_req(8'h22);
        chk("R9 preempt", {7'd0, int_req}, 8'd1);
        do_ack(c, v);
        chk("R10 ack_vec 2", v, 8'h81);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R6 eoi highest", v, 8'h08);
        wr(1'b1, 8'hFF);
        #1 chk("R9 all masked", {7'd0, int_req}, 8'd0);
        do_ack(c, v);
        chk("R10 spurious vec", v, 8'h87);
        chk("R10 spurious no clr", c, 8'h00);
        rd(1'b0, v); chk("R10 spurious isr", v, 8'h08);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_rotate();
        logic [7:0] c, v;
        wr(1'b0, 8'hA0);
        rd(1'b0, v); chk("R6 rotating eoi clear", v, 8'h00);
        set_req(8'h41);
        do_ack(c, v); chk("R6 offset line+1", v, 8'h86);
        wr(1'b0, 8'h66);
        rd(1'b0, v); chk("R7 specific eoi", v, 8'h00);
        wr(1'b0, 8'hC7);
        do_ack(c, v); chk("R8 set priority wrap", v, 8'h80);
        wr(1'b0, 8'hC4);
        #1 chk("R8 rotated preempt", {7'd0, int_req}, 8'd1);
        do_ack(c, v); chk("R8 set priority 4", v, 8'h86);
        wr(1'b0, 8'h20);
        rd(1'b0, v); chk("R6 eoi under rotation", v, 8'h01);
        wr(1'b0, 8'hE0);
        rd(1'b0, v); chk("R7 rotating specific clear", v, 8'h00);
        set_req(8'h09);
        do_ack(c, v); chk("R7 offset after code 7", v, 8'h83);
        wr(1'b0, 8'h40);
        rd(1'b0, v); chk("R8 code 2 no effect", v, 8'h08);
        wr(1'b0, 8'h63);
        level_sel = 8'h08; set_req(8'h08);
        do_ack(c, v);
        chk("R10 level not cleared", c, 8'h00);
        chk("R10 level vec", v, 8'h83);
        wr(1'b0, 8'h63);
        level_sel = 8'h00;
    endtask

    task automatic t_aeoi();
        logic [7:0] c, v;
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h00); wr(1'b1, 8'h02);
        wr(1'b0, 8'h0B);
        set_req(8'h10);
        do_ack(c, v); chk("R11 vec", v, 8'h24);
        rd(1'b0, v); chk("R11 isr untouched", v, 8'h00);
        wr(1'b0, 8'h80);
        set_req(8'h11);
        do_ack(c, v); chk("R11 first", v, 8'h20);
        do_ack(c, v); chk("R11 rotated", v, 8'h24);
        wr(1'b0, 8'h00);
        do_ack(c, v);
        do_ack(c, v); chk("R8 rotate flag off", v, 8'h20);
    endtask

    task automatic t_poll();
        logic [7:0] c, v;
        wr(1'b0, 8'h10); wr(1'b1, 8'h08); wr(1'b1, 8'h00);
        set_req(8'h44);
        wr(1'b0, 8'h0C);
        rd_en = 1'b1; addr = 1'b0;
        #1 c = req_clr;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 poll req_clr", c, 8'h04);
        chk("R12 poll line", rd_data, 8'h02);
        rd(1'b0, v); chk("R12 poll cleared", v, 8'h44);
        set_req(8'h40);
        do_ack(c, v); chk("R10 vec base 8", v, 8'h0E);
        wr(1'b0, 8'h0C);
        rd_en = 1'b1; addr = 1'b0;
        #1 c = req_clr;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 none clr", c, 8'h00);
        chk("R12 none line", rd_data, 8'h07);
        wr(1'b0, 8'h66);
        set_req(8'h44);
    endtask

    task automatic t_sel();
        logic [7:0] v;
        wr(1'b0, 8'h0B);
        rd(1'b0, v); chk("R13 isr select", v, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); chk("R13 req select", v, 8'h44);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h08);
        rd(1'b0, v); chk("R5 select kept", v, 8'h00);
        wr(1'b0, 8'h68); chk("R5 spec on", {7'd0, spec_mask}, 8'd1);
        wr(1'b0, 8'h28); chk("R5 spec kept", {7'd0, spec_mask}, 8'd1);
        wr(1'b0, 8'h48); chk("R5 spec off", {7'd0, spec_mask}, 8'd0);
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h10);
        chk("R2 spec cleared", {7'd0, spec_mask}, 8'd0);
        rd(1'b0, v); chk("R2 select cleared", v, 8'h44);
        wr(1'b1, 8'h00); wr(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init();
        t_ack();
        t_rotate();
        t_aeoi();
        t_poll();
        t_sel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule